// File: doc/BRIEF.md
# Dual Digital Phase Detector

This block holds the two phase comparators of an all-digital phase-locked loop. One comparator is an exclusive-OR detector. It compares a first reference input with a feedback input. The other is an edge-triggered set/clear detector. It compares a second reference input with the same feedback input. Either output can drive the up/down direction input of the loop's counter. The loop counter and the pulse add/remove stage sit outside this block.

All three phase inputs are asynchronous. Each passes through a synchronizer into the single system clock domain. Edges are found by comparing each synchronized sample with the one before it, and both outputs are registered.

The exclusive-OR detector has a gain of 4. Its output reaches a square wave when its inputs are a quarter cycle apart, and it saturates at a quarter cycle of error. The edge detector has a gain of 2. Its square-wave point is at half a cycle of separation, and it saturates at half a cycle.

Top module: `dual_phase_det`

## Requirements
- R1: While `rst_ni` is low, both outputs are 0 and the edge history is cleared. An input that is already high when reset is released produces no falling edge.
- R2: `xor_pd_o` is 1 when the synchronized `ref_xor_i` and `fb_i` differ, and 0 when they are equal.
- R3: An input change driven between clock edges shows at the outputs after the third rising clock edge that follows it. The outputs are unchanged after the second.
- R4: A falling edge on `fb_i` alone sets `edge_pd_o` to 1, whatever the level of `ref_edge_i`.
- R5: A falling edge on `ref_edge_i` alone clears `edge_pd_o` to 0, whatever the level of `fb_i`.
- R6: Rising edges on `fb_i` or `ref_edge_i` leave `edge_pd_o` unchanged.
- R7: When falling edges on `fb_i` and `ref_edge_i` are detected in the same clock, `edge_pd_o` inverts.
- R8: `ref_xor_i` has no effect on `edge_pd_o`, and `ref_edge_i` has no effect on `xor_pd_o`.
- R9: Take square waves with a period of P clocks, where `ref_xor_i` and `ref_edge_i` lead `fb_i` by d clocks (0 < d <= P/2). Then `xor_pd_o` is high for 2d clocks per period and `edge_pd_o` for P-d clocks per period. This gives a 50% duty at d = P/4 for the exclusive-OR detector and at d = P/2 for the edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_xor_i | input | 1 | Reference phase for the exclusive-OR detector (asynchronous) |
| ref_edge_i | input | 1 | Reference phase for the edge detector; its falling edge clears the output |
| fb_i | input | 1 | Shared feedback phase; its falling edge sets the edge detector output |
| xor_pd_o | output | 1 | Exclusive-OR detector output |
| edge_pd_o | output | 1 | Edge-triggered detector output |

## Verification
The assertions relate the edge events found by the synchronizers to the next value of the edge detector output. They assume that each phase input holds every level for at least one sampling clock, because a shorter pulse can be lost by the synchronizer and would then show as no event at all. The stimulus changes inputs only at falling clock edges and holds every level for at least three clocks. It sweeps all 64 pairs of successive 3-bit input states, which covers lone and simultaneous falling edges. It then drives periodic waveforms at several phase offsets and counts the high cycles of each output over whole periods.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned PD_NUM_IN   = 3;
  localparam int unsigned PD_IDX_XOR  = 0;
  localparam int unsigned PD_IDX_EDGE = 1;
  localparam int unsigned PD_IDX_FB   = 2;

  typedef struct packed {
    logic lvl;   // synchronized level
    logic fall;  // high for one clock after a detected 1->0
  } pd_sample_t;
endpackage

// File: rtl/pd_sync.sv
module pd_sync
  import pd_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       async_i,
  output pd_sample_t sample_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign sample_o.lvl  = chain_q[STAGES-1];
  assign sample_o.fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pd_xor.sv
module pd_xor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= a_i ^ b_i;
  end
endmodule

// File: rtl/pd_edge.sv
module pd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else begin
      unique case ({set_i, clr_i})
        2'b10:   q_o <= 1'b1;
        2'b01:   q_o <= 1'b0;
        2'b11:   q_o <= ~q_o;  // coincident edges: keep long-run duty
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/dual_phase_det.sv
module dual_phase_det
  import pd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_xor_i,
  input  logic ref_edge_i,
  input  logic fb_i,
  output logic xor_pd_o,
  output logic edge_pd_o
);
  localparam int unsigned NUM_IN = PD_NUM_IN;

  logic [NUM_IN-1:0] raw;
  pd_sample_t        smp [NUM_IN];

  assign raw[PD_IDX_XOR]  = ref_xor_i;
  assign raw[PD_IDX_EDGE] = ref_edge_i;
  assign raw[PD_IDX_FB]   = fb_i;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (raw[g]),
      .sample_o(smp[g])
    );
  end

  pd_xor u_xor (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (smp[PD_IDX_XOR].lvl),
    .b_i   (smp[PD_IDX_FB].lvl),
    .q_o   (xor_pd_o)
  );

  pd_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (smp[PD_IDX_FB].fall),
    .clr_i (smp[PD_IDX_EDGE].fall),
    .q_o   (edge_pd_o)
  );

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_rst_low_R1: assert (!edge_pd_o && !xor_pd_o)
        else $error("outputs not low in reset");
    end
  end

  assert_fb_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp[PD_IDX_FB].fall && !smp[PD_IDX_EDGE].fall |=> edge_pd_o);

  assert_ref_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp[PD_IDX_EDGE].fall && !smp[PD_IDX_FB].fall |=> !edge_pd_o);

  assert_rise_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smp[PD_IDX_EDGE].lvl) && !smp[PD_IDX_FB].fall |=> $stable(edge_pd_o));

  assert_coincide_flips_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp[PD_IDX_FB].fall && smp[PD_IDX_EDGE].fall |=> edge_pd_o != $past(edge_pd_o));
endmodule

// File: tb/sim_dual_phase_det.sv
module sim_dual_phase_det;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int PER        = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_xor = 1'b0, ref_edge = 1'b0, fb = 1'b0;
  logic xor_pd, edge_pd;

  int vectors = 0;
  int miscompares = 0;
  logic m_edge = 1'b0;
  logic p_fb = 1'b0, p_ref = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_phase_det u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_xor_i (ref_xor),
    .ref_edge_i(ref_edge),
    .fb_i      (fb),
    .xor_pd_o  (xor_pd),
    .edge_pd_o (edge_pd)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // v = {fb, ref_edge, ref_xor}
  task automatic apply(input logic [2:0] v);
    logic x_old, e_old, x_new, f_fall, r_fall;
    string etag;
    @(negedge clk);
    x_old = ref_xor ^ fb;
    e_old = m_edge;
    {fb, ref_edge, ref_xor} = v;
    x_new  = v[0] ^ v[2];
    f_fall = p_fb & ~v[2];
    r_fall = p_ref & ~v[1];
    if (f_fall && r_fall)      begin m_edge = ~m_edge; etag = "R7 coincident"; end
    else if (f_fall)           begin m_edge = 1'b1;    etag = "R4 fb fall"; end
    else if (r_fall)           begin m_edge = 1'b0;    etag = "R5 ref fall"; end
    else                             etag = "R6/R8 hold";
    p_fb  = v[2];
    p_ref = v[1];
    repeat (2) @(posedge clk);
    #(QTR);
    check("R3 xor latency", int'(xor_pd), int'(x_old));
    check("R3 edge latency", int'(edge_pd), int'(e_old));
    @(posedge clk);
    #(QTR);
    check("R2/R8 xor", int'(xor_pd), int'(x_new));
    check(etag, int'(edge_pd), int'(m_edge));
  endtask

  task automatic duty(input int d);
    int xh = 0, eh = 0;
    for (int c = 0; c < 6*PER; c++) begin
      @(negedge clk);
      if (c >= 2*PER) begin
        xh += int'(xor_pd);
        eh += int'(edge_pd);
      end
      fb       = (c % PER) < PER/2;
      ref_xor  = ((c + d) % PER) < PER/2;
      ref_edge = ((c + d) % PER) < PER/2;
    end
    check($sformatf("R9 xor duty d=%0d", d), xh, 4*2*d);
    check($sformatf("R9 edge duty d=%0d", d), eh, 4*(PER-d));
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    fb = 1'b1; ref_edge = 1'b1; ref_xor = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 xor in reset", int'(xor_pd), 0);
    check("R1 edge in reset", int'(edge_pd), 0);
    rst_n = 1'b1;
    p_fb = 1'b1; p_ref = 1'b1; m_edge = 1'b0;
    repeat (6) @(negedge clk);
    #(QTR);
    check("R1 no spurious edge", int'(edge_pd), 0);
    check("R1 xor after release", int'(xor_pd), 0);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        apply(3'(i));
        apply(3'(j));
      end
    end

    duty(2);
    duty(4);
    duty(6);
    duty(8);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule